// File: doc/BRIEF.md
# Bus-Master DMA Control Register Set

This block holds, for each DMA channel of a disk host adapter, the three registers software uses to run a scatter/gather transfer. The first is a command byte that holds a start flag and a direction flag. The second is a status byte that mixes writable, read-only and write-one-to-clear bits. The third is a 32-bit pointer to the descriptor table in memory.

Software uses the block in a fixed order:
1. It loads the descriptor pointer.
2. It issues the device command elsewhere.
3. It sets the start flag.

The block then pulses a launch signal toward a separate DMA engine. When the engine reports completion or failure, the block ends the transfer and raises the channel's interrupt. The block does not walk the descriptor table, move data or decode device commands.

The register window of a channel is eight bytes wide. The low three address bits select the register, and the address bits above them select the channel. Reads are combinational through a byte-wide data port. Writes take effect on the clock edge where the write strobe is high.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, every register of every channel reads 0, and every interrupt, launch, rewind and size-error output is low.
- R2: A command write (offset 0) on an idle channel with bit 0 set does all of the following:
  - stores bit 0 (start) and bit 3 (direction);
  - sets status bit 0 (active);
  - pulses `xfer_start` for exactly one cycle;
  - drives `xfer_to_mem` from bit 3, where 1 means device data is written into memory.
- R3: A command write on an idle channel with bit 0 clear stores the direction bit and pulses `tbl_rewind` for one cycle, which tells the engine to reset its descriptor index to zero. It does not pulse `xfer_start`.
- R4: While a transfer runs, command writes are ignored. The command byte, active bit and outputs stay unchanged, so a launched transfer cannot be aborted.
- R5: A `xfer_done` pulse on a running channel has three effects on the following edge:
  - the start bit clears;
  - status bit 0 clears;
  - status bit 2 (interrupt) sets, and `irq` follows it high.
- R6: A `xfer_fail` pulse on a running channel ends the transfer the same way as R5. It also sets status bit 1 (error).
- R7: A one-byte status write (offset 2) gives a new status equal to (written AND 0x60) OR (old AND 0x01) OR (old AND NOT written AND 0x06). Bits 7, 4 and 3 read 0.
- R8: A status write flagged `reg_wide` (access wider than one byte) leaves the status unchanged and pulses `reg_err` for one cycle.
- R9: Byte writes at offsets 4, 5, 6 and 7 load pointer bits 7:0, 15:8, 23:16 and 31:24. Pointer bits 1:0 always read 0, on the port and on `desc_base`.
- R10: Address bit 3 selects the channel. An access to one channel leaves the other channel's registers and outputs unchanged.
- R11: `xfer_done` and `xfer_fail` on an idle channel change nothing.
- R12: Reads of offsets 1 and 3 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wide | input | 1 | The current access is wider than one byte |
| reg_addr | input | ADDR_W (4) | Bit 3 selects the channel, bits 2:0 select the register byte |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| reg_err | output | 1 | One-cycle pulse after a rejected wide status write |
| xfer_start | output | NCH | One-cycle launch pulse per channel |
| xfer_to_mem | output | NCH | Direction per channel; 1 means device to memory |
| xfer_done | input | NCH | Engine reports that the transfer finished |
| xfer_fail | input | NCH | Engine reports that the transfer failed |
| tbl_rewind | output | NCH | One-cycle request to reset the descriptor index |
| desc_base | output | NCH*32 | Descriptor table pointer; channel c is at bits [32c+31:32c] |
| irq | output | NCH | Interrupt level per channel (status bit 2) |

## Verification
A wrong active flag in a channel would show up at the ports within one cycle, in two ways. The channel would accept or drop a command write it should not, which is visible on `xfer_start` or `tbl_rewind`. Or the channel would ignore an engine completion, which is visible on `irq`. A wrong merge of the status bits shows up on the next status read. The bench therefore builds each reachable combination of old status bits before every written byte value and reads the result back at once. Pointer lanes, channel isolation and the engine events are each checked in the cycle after the stimulus.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;

    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_STAT = 3'd2;

    localparam int CMD_GO_BIT  = 0;
    localparam int CMD_DIR_BIT = 3;

    localparam logic [7:0] STAT_SW_MASK  = 8'h60;
    localparam logic [7:0] STAT_RO_MASK  = 8'h01;
    localparam logic [7:0] STAT_W1C_MASK = 8'h06;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_CMD,
        SEL_STAT,
        SEL_PTR
    } reg_sel_e;

    // status bits held in flops apart from the active flag
    typedef struct packed {
        logic [1:0] sw;
        logic       intr;
        logic       err;
    } stat_keep_t;

    function automatic logic [7:0] stat_pack(input stat_keep_t k, input logic act);
        return {1'b0, k.sw, 2'b00, k.intr, k.err, act};
    endfunction

    function automatic logic [7:0] stat_merge(input logic [7:0] old, input logic [7:0] wv);
        return (wv & STAT_SW_MASK) | (old & STAT_RO_MASK) | (old & ~wv & STAT_W1C_MASK);
    endfunction

    function automatic logic [7:0] cmd_pack(input logic go, input logic dir);
        logic [7:0] b;
        b = 8'h00;
        b[CMD_GO_BIT]  = go;
        b[CMD_DIR_BIT] = dir;
        return b;
    endfunction

endpackage

// File: rtl/bmdma_addr_dec.sv
module bmdma_addr_dec
    import bmdma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int CH_W   = 1,
    parameter int ADDR_W = 4
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    output reg_sel_e          sel_o,
    output logic [CH_W-1:0]   ch_o,
    output logic              ch_ok_o,
    output logic [1:0]        lane_o,
    output logic [NCH-1:0]    cmd_we_o,
    output logic [NCH-1:0]    st_we_o,
    output logic [NCH-1:0]    ptr_we_o
);

    logic [2:0] ofs;

    always_comb begin
        ofs     = addr_i[2:0];
        ch_o    = addr_i[ADDR_W-1:3];
        ch_ok_o = (int'(ch_o) < NCH);
        lane_o  = ofs[1:0];
        if (ofs[2])               sel_o = SEL_PTR;
        else if (ofs == OFS_CMD)  sel_o = SEL_CMD;
        else if (ofs == OFS_STAT) sel_o = SEL_STAT;
        else                      sel_o = SEL_NONE;
    end

    for (genvar c = 0; c < NCH; c++) begin : g_we
        logic hit;
        assign hit         = wr_i && (ch_o == CH_W'(c));
        assign cmd_we_o[c] = hit && (sel_o == SEL_CMD);
        assign st_we_o[c]  = hit && (sel_o == SEL_STAT);
        assign ptr_we_o[c] = hit && (sel_o == SEL_PTR);
    end

endmodule

// File: rtl/bmdma_desc_ptr.sv
module bmdma_desc_ptr #(
    parameter int PTR_W  = 32,
    parameter int LANE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we_i,
    input  logic [LANE_W-1:0] lane_i,
    input  logic [7:0]        wdata_i,
    output logic [PTR_W-1:0]  ptr_o
);

    localparam int NLANE = PTR_W / 8;

    logic [PTR_W-1:0] ptr_q;

    for (genvar l = 0; l < NLANE; l++) begin : g_lane
        logic [7:0] lane_d;
        if (l == 0) begin : g_low
            assign lane_d = {wdata_i[7:2], 2'b00};
        end else begin : g_hi
            assign lane_d = wdata_i;
        end
        always_ff @(posedge clk) begin
            if (rst)
                ptr_q[l*8 +: 8] <= 8'h00;
            else if (we_i && (lane_i == LANE_W'(l)))
                ptr_q[l*8 +: 8] <= lane_d;
        end
    end

    assign ptr_o = ptr_q;

    p_ptr_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !we_i |=> $stable(ptr_q));

endmodule

// File: rtl/bmdma_chan_ctl.sv
module bmdma_chan_ctl
    import bmdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_we_i,
    input  logic       st_we_i,
    input  logic       st_wide_i,
    input  logic [7:0] wdata_i,
    input  logic       done_i,
    input  logic       fail_i,
    output logic [7:0] cmd_byte_o,
    output logic [7:0] st_byte_o,
    output logic       start_o,
    output logic       rewind_o,
    output logic       dir_o,
    output logic       irq_o,
    output logic       size_err_o
);

    logic       run_q, dir_q, start_q, rewind_q, serr_q;
    stat_keep_t keep_q;

    logic       ev, cmd_ok, st_ok;
    logic [7:0] old_b, mrg;
    stat_keep_t keep_d;
    logic       run_d, dir_d;

    always_comb begin
        ev     = run_q && (done_i || fail_i);
        cmd_ok = cmd_we_i && !run_q;
        st_ok  = st_we_i && !st_wide_i;
        old_b  = stat_pack(keep_q, run_q);
        mrg    = st_ok ? stat_merge(old_b, wdata_i) : old_b;
        keep_d.sw   = mrg[6:5];
        keep_d.intr = mrg[2] | ev;
        keep_d.err  = mrg[1] | (ev && fail_i);
        if (ev)          run_d = 1'b0;
        else if (cmd_ok) run_d = wdata_i[CMD_GO_BIT];
        else             run_d = run_q;
        dir_d = cmd_ok ? wdata_i[CMD_DIR_BIT] : dir_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q    <= 1'b0;
            dir_q    <= 1'b0;
            keep_q   <= '0;
            start_q  <= 1'b0;
            rewind_q <= 1'b0;
            serr_q   <= 1'b0;
        end else begin
            run_q    <= run_d;
            dir_q    <= dir_d;
            keep_q   <= keep_d;
            start_q  <= cmd_ok && wdata_i[CMD_GO_BIT];
            rewind_q <= cmd_ok && !wdata_i[CMD_GO_BIT];
            serr_q   <= st_we_i && st_wide_i;
        end
    end

    assign cmd_byte_o = cmd_pack(run_q, dir_q);
    assign st_byte_o  = stat_pack(keep_q, run_q);
    assign start_o    = start_q;
    assign rewind_o   = rewind_q;
    assign dir_o      = dir_q;
    assign irq_o      = keep_q.intr;
    assign size_err_o = serr_q;

    p_launch_from_idle_r2: assert property (@(posedge clk) disable iff (rst)
        start_q |-> (run_q && !$past(run_q)));

    p_rewind_idle_r3: assert property (@(posedge clk) disable iff (rst)
        rewind_q |-> !run_q);

    p_no_abort_r4: assert property (@(posedge clk) disable iff (rst)
        (run_q && !done_i && !fail_i) |=> run_q);

    p_done_irq_r5: assert property (@(posedge clk) disable iff (rst)
        (run_q && done_i) |=> (irq_o && !run_q));

    p_fail_err_r6: assert property (@(posedge clk) disable iff (rst)
        (run_q && fail_i) |=> (keep_q.err && !run_q));

    p_active_ro_r7: assert property (@(posedge clk) disable iff (rst)
        (st_we_i && !cmd_we_i && !run_q) |=> !run_q);

    p_wide_reject_r8: assert property (@(posedge clk) disable iff (rst)
        (st_we_i && st_wide_i && !run_q && !cmd_we_i) |=> ($stable(keep_q) && serr_q));

    p_idle_event_r11: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !cmd_we_i && !st_we_i && (done_i || fail_i)) |=> ($stable(keep_q) && !run_q));

endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
    import bmdma_pkg::*;
#(
    parameter int NCH    = 2,
    parameter int PTR_W  = 32,
    parameter int ADDR_W = 3 + ((NCH > 1) ? $clog2(NCH) : 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 reg_wr,
    input  logic                 reg_wide,
    input  logic [ADDR_W-1:0]    reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    output logic                 reg_err,
    output logic [NCH-1:0]       xfer_start,
    output logic [NCH-1:0]       xfer_to_mem,
    input  logic [NCH-1:0]       xfer_done,
    input  logic [NCH-1:0]       xfer_fail,
    output logic [NCH-1:0]       tbl_rewind,
    output logic [NCH*PTR_W-1:0] desc_base,
    output logic [NCH-1:0]       irq
);

    localparam int CH_W = ADDR_W - 3;

    reg_sel_e        sel;
    logic [CH_W-1:0] ch;
    logic            ch_ok;
    logic [1:0]      lane;
    logic [NCH-1:0]  cmd_we, st_we, ptr_we, serr;
    logic [7:0]      cmd_b [NCH];
    logic [7:0]      st_b  [NCH];
    logic [PTR_W-1:0] ptr_v [NCH];

    bmdma_addr_dec #(.NCH(NCH), .CH_W(CH_W), .ADDR_W(ADDR_W)) u_dec (
        .addr_i  (reg_addr),
        .wr_i    (reg_wr),
        .sel_o   (sel),
        .ch_o    (ch),
        .ch_ok_o (ch_ok),
        .lane_o  (lane),
        .cmd_we_o(cmd_we),
        .st_we_o (st_we),
        .ptr_we_o(ptr_we)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        bmdma_chan_ctl u_ctl (
            .clk       (clk),
            .rst       (rst),
            .cmd_we_i  (cmd_we[c]),
            .st_we_i   (st_we[c]),
            .st_wide_i (reg_wide),
            .wdata_i   (reg_wdata),
            .done_i    (xfer_done[c]),
            .fail_i    (xfer_fail[c]),
            .cmd_byte_o(cmd_b[c]),
            .st_byte_o (st_b[c]),
            .start_o   (xfer_start[c]),
            .rewind_o  (tbl_rewind[c]),
            .dir_o     (xfer_to_mem[c]),
            .irq_o     (irq[c]),
            .size_err_o(serr[c])
        );

        bmdma_desc_ptr #(.PTR_W(PTR_W), .LANE_W(2)) u_ptr (
            .clk    (clk),
            .rst    (rst),
            .we_i   (ptr_we[c]),
            .lane_i (lane),
            .wdata_i(reg_wdata),
            .ptr_o  (ptr_v[c])
        );

        assign desc_base[c*PTR_W +: PTR_W] = ptr_v[c];
    end

    assign reg_err = |serr;

    always_comb begin
        reg_rdata = 8'h00;
        for (int c = 0; c < NCH; c++) begin
            if (ch_ok && (int'(ch) == c)) begin
                case (sel)
                    SEL_CMD:  reg_rdata = cmd_b[c];
                    SEL_STAT: reg_rdata = st_b[c];
                    SEL_PTR:  reg_rdata = ptr_v[c][lane*8 +: 8];
                    default:  reg_rdata = 8'h00;
                endcase
            end
        end
    end

    p_one_target_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_we, st_we, ptr_we}));

endmodule

// File: tb/bmdma_regs_test.sv
`timescale 1ns/1ps
module bmdma_regs_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0, reg_wide = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        reg_err;
    logic [1:0]  xfer_start, xfer_to_mem, tbl_rewind, irq;
    logic [1:0]  xfer_done = '0, xfer_fail = '0;
    logic [63:0] desc_base;

    int nvec = 0;
    int nbad = 0;

    always #10 clk = ~clk;

    bmdma_regs uut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_wide(reg_wide),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_err(reg_err), .xfer_start(xfer_start), .xfer_to_mem(xfer_to_mem),
        .xfer_done(xfer_done), .xfer_fail(xfer_fail), .tbl_rewind(tbl_rewind),
        .desc_base(desc_base), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nbad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wreg(input int ch, input int ofs, input logic [7:0] d, input bit wide = 1'b0);
        @(negedge clk);
        reg_wr    = 1'b1;
        reg_wide  = wide;
        reg_addr  = {ch[0], ofs[2:0]};
        reg_wdata = d;
        @(negedge clk);
        reg_wr   = 1'b0;
        reg_wide = 1'b0;
    endtask

    task automatic rreg(input int ch, input int ofs, output logic [7:0] v);
        reg_addr = {ch[0], ofs[2:0]};
        #1;
        v = reg_rdata;
    endtask

    task automatic ev_done(input int ch);
        @(negedge clk);
        xfer_done[ch] = 1'b1;
        @(negedge clk);
        xfer_done = '0;
    endtask

    task automatic ev_fail(input int ch);
        @(negedge clk);
        xfer_fail[ch] = 1'b1;
        @(negedge clk);
        xfer_fail = '0;
    endtask

    // build status value o (bits 6,5,2,1,0) on channel 0
    task automatic set_old(input logic [7:0] o);
        logic [7:0] v;
        rreg(0, 2, v);
        if (v[0]) ev_done(0);
        wreg(0, 2, 8'h06);
        if (o[1]) begin
            wreg(0, 0, 8'h01);
            ev_fail(0);
            if (!o[2]) wreg(0, 2, 8'h04);
        end else if (o[2]) begin
            wreg(0, 0, 8'h01);
            ev_done(0);
        end
        wreg(0, 2, o & 8'h60);
        if (o[0]) wreg(0, 0, 8'h01);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog: actual 0x0 expected 0x1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        logic [7:0] v, o, expv;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int c = 0; c < 2; c++)
            for (int a = 0; a < 8; a++) begin
                rreg(c, a, v);
                chk("R1 reg after reset", v, 0);
            end
        chk("R1 outputs after reset",
            {reg_err, xfer_start, tbl_rewind, irq, xfer_to_mem}, 0);

        // R2 launch, device to memory
        wreg(0, 0, 8'h09);
        chk("R2 start pulse", xfer_start, 2'b01);
        chk("R2 direction", xfer_to_mem, 2'b01);
        rreg(0, 2, v); chk("R2 active", v, 8'h01);
        rreg(0, 0, v); chk("R2 cmd byte", v, 8'h09);
        @(negedge clk);
        chk("R2 pulse one cycle", xfer_start, 0);

        // R4 no abort
        wreg(0, 0, 8'h00);
        chk("R4 no rewind while running", tbl_rewind, 0);
        rreg(0, 0, v); chk("R4 cmd kept", v, 8'h09);
        rreg(0, 2, v); chk("R4 active kept", v, 8'h01);

        // R5 completion
        ev_done(0);
        chk("R5 irq", irq, 2'b01);
        rreg(0, 2, v); chk("R5 status", v, 8'h04);
        rreg(0, 0, v); chk("R5 start cleared", v, 8'h08);

        // R11 idle events ignored
        ev_done(0);
        ev_fail(0);
        rreg(0, 2, v); chk("R11 idle events", v, 8'h04);

        // R3 rewind
        wreg(0, 0, 8'h00);
        chk("R3 rewind pulse", tbl_rewind, 2'b01);
        chk("R3 no launch", xfer_start, 0);
        chk("R3 direction stored", xfer_to_mem, 0);

        // R6 failure
        wreg(0, 2, 8'h04);
        chk("R6 irq cleared first", irq, 0);
        wreg(0, 0, 8'h01);
        chk("R6 launch mem to device", xfer_to_mem, 0);
        ev_fail(0);
        rreg(0, 2, v); chk("R6 status", v, 8'h06);
        chk("R6 irq", irq, 2'b01);

        // R8 wide status write rejected
        wreg(0, 2, 8'h66, 1'b1);
        chk("R8 size error pulse", reg_err, 1);
        rreg(0, 2, v); chk("R8 status unchanged", v, 8'h06);
        wreg(0, 2, 8'h66);
        chk("R8 no error on byte write", reg_err, 0);
        rreg(0, 2, v); chk("R8 byte write applies", v, 8'h60);

        // R9 descriptor pointer
        wreg(0, 4, 8'hFF); wreg(0, 5, 8'h12); wreg(0, 6, 8'h34); wreg(0, 7, 8'h56);
        chk("R9 pointer output", desc_base[31:0], 32'h563412FC);
        rreg(0, 4, v); chk("R9 low byte read", v, 8'hFC);
        rreg(0, 7, v); chk("R9 high byte read", v, 8'h56);

        // R10 channel isolation
        wreg(1, 0, 8'h01);
        chk("R10 ch1 launch only", xfer_start, 2'b10);
        rreg(0, 2, v); chk("R10 ch0 status untouched", v, 8'h60);
        wreg(1, 4, 8'hAB);
        chk("R10 ch1 pointer", desc_base[63:32], 32'h000000A8);
        chk("R10 ch0 pointer kept", desc_base[31:0], 32'h563412FC);
        ev_done(1);
        chk("R10 ch1 irq only", irq, 2'b10);

        // R12 gap offsets
        rreg(0, 1, v); chk("R12 offset 1", v, 0);
        rreg(1, 3, v); chk("R12 offset 3", v, 0);

        // R7 sweep of old status against every written byte
        for (int oi = 0; oi < 32; oi++) begin
            o = {1'b0, oi[4:3], 2'b00, oi[2:0]};
            for (int w = 0; w < 256; w++) begin
                set_old(o);
                wreg(0, 2, w[7:0]);
                expv = (w[7:0] & 8'h60) | (o & 8'h01) | (o & ~w[7:0] & 8'h06);
                rreg(0, 2, v);
                chk("R7 status merge", v, expv);
            end
        end

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule